// File: doc/BRIEF.md
# Hilbert-capable radix-2 butterfly

This block is the single arithmetic engine of a memory-based transform processor that computes a discrete Hilbert transform by running a forward radix-2 decimation-in-frequency FFT, scaling the spectrum by −j, 0 or +j, and running an inverse FFT. Each clock it takes one pair of complex samples, a complex twiddle and a set of mode flags, and after a fixed number of cycles it returns a pair of complex results with a valid strobe. Addressing, the memories and twiddle storage belong to the surrounding controller.

In plain mode it is an ordinary DIF butterfly. The FFT's last stage, the spectral multiply and the IFFT's first stage are folded into one swap-mode pass that needs no arithmetic. A zero mode clears the pair that holds the DC and Nyquist bins. A rotate mode lets the twiddle store hold first-quadrant factors only. A conjugate mode negates imaginary parts on the final write-back. A parity flag exchanges the two samples on the way in and the two results on the way out, because the controller pairs memory banks by address parity. Arithmetic is signed fixed point of width `W`, with the twiddle in Q(W−1). Results keep the low `W` bits, so sums and differences wrap and products are truncated. The latency `LAT` must be 2 or more.

Top module: `hilbert_bfly`

## Requirements
- R1: With all mode flags low and parity 0, out_a = (ar+br, ai+bi), each part reduced to its low W bits.
- R2: With all mode flags low and parity 0, with d = a−b (each part reduced to W bits), out_b real = (dr·c − di·s) >>> (W−1) and out_b imag = (dr·s + di·c) >>> (W−1), arithmetic shift, low W bits kept, where c = tw_cos and s = tw_sin.
- R3: With rot_en high and swp_en low, d is replaced by (di, −dr) (negation wrapped to W bits) before the twiddle product of R2.
- R4: With swp_en high and clr_en low, out_a = (bi, br) and out_b = (ai, ar), whatever the twiddle, and regardless of parity.
- R5: With clr_en high, all four output parts are zero, whatever the other flags and data.
- R6: With cnj_en high, the imaginary parts of both results are negated (wrapped to W bits) after every other mode has been applied.
- R7: With parity 1, a and b are exchanged before the butterfly and the two results are exchanged after it, so in plain mode out_a carries the twiddled difference (b−a)·W and out_b carries a+b.
- R8: out_vld is in_vld delayed by exactly LAT cycles, a new pair is accepted on every clock, and each result belongs to the pair accepted LAT cycles earlier.
- R9: While rst_n is low, out_vld is 0.
- R10: rot_en has no effect when swp_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input pair valid |
| in_ar | input | W | Sample a, real |
| in_ai | input | W | Sample a, imaginary |
| in_br | input | W | Sample b, real |
| in_bi | input | W | Sample b, imaginary |
| tw_cos | input | W | Twiddle real part, Q(W−1) |
| tw_sin | input | W | Twiddle imaginary part, Q(W−1) |
| par | input | 1 | Bank parity: swap inputs and outputs |
| swp_en | input | 1 | Merged swap stage |
| clr_en | input | 1 | Force results to zero |
| rot_en | input | 1 | Second-quadrant twiddle rotation |
| cnj_en | input | 1 | Conjugate results on write-back |
| out_vld | output | 1 | Result pair valid |
| out_ar | output | W | Result a, real |
| out_ai | output | W | Result a, imaginary |
| out_br | output | W | Result b, real |
| out_bi | output | W | Result b, imaginary |

## Verification
If a mode flag gets out of step with its data in the pipeline, the swap, zero or conjugate pattern appears on the neighbouring result pair, and the comparison shows it exactly LAT cycles after the bad pair went in. A wrong sign or operand order inside the twiddle product shows up on the first plain-mode pair with a nonzero difference, because random twiddles make every cross term visible. A missed parity exchange shows up as the sum and the product landing on the wrong output. All of these are compared on each valid result, so no fault can stay hidden for more than one pair.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  typedef struct packed {
    logic clr;
    logic swp;
    logic cnj;
    logic par;
  } hbf_mode_t;
endpackage

// File: rtl/hbf_prep.sv
module hbf_prep #(
  parameter int W = 16
) (
  input  logic                par,
  input  logic                rot,
  input  logic signed [W-1:0] ar,
  input  logic signed [W-1:0] ai,
  input  logic signed [W-1:0] br,
  input  logic signed [W-1:0] bi,
  output logic signed [W-1:0] xr,
  output logic signed [W-1:0] xi,
  output logic signed [W-1:0] yr,
  output logic signed [W-1:0] yi,
  output logic signed [W-1:0] sr,
  output logic signed [W-1:0] si,
  output logic signed [W-1:0] dr,
  output logic signed [W-1:0] di
);
  logic signed [W-1:0] ddr, ddi, ndr;

  always_comb begin
    xr = par ? br : ar;
    xi = par ? bi : ai;
    yr = par ? ar : br;
    yi = par ? ai : bi;
    sr = xr + yr;
    si = xi + yi;
    ddr = xr - yr;
    ddi = xi - yi;
    ndr = -ddr;
    dr = rot ? ddi : ddr;
    di = rot ? ndr : ddi;
  end
endmodule

// File: rtl/hbf_cmul.sv
module hbf_cmul #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] dr,
  input  logic signed [W-1:0] di,
  input  logic signed [W-1:0] c,
  input  logic signed [W-1:0] s,
  output logic signed [W-1:0] pr,
  output logic signed [W-1:0] pi
);
  localparam int FW = 2 * W + 1;
  logic signed [FW-1:0] fr, fi;

  always_comb begin
    fr = FW'(dr * c) - FW'(di * s);
    fi = FW'(dr * s) + FW'(di * c);
    pr = fr[2*W-2:W-1];
    pi = fi[2*W-2:W-1];
  end
endmodule

// File: rtl/hbf_dly.sv
module hbf_dly #(
  parameter int DW    = 64,
  parameter int DEPTH = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_vld,
  input  logic [DW-1:0] i_dat,
  output logic          o_vld,
  output logic [DW-1:0] o_dat
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign o_vld = i_vld;
      assign o_dat = i_dat;
    end else begin : g_chain
      logic          v_q [DEPTH];
      logic [DW-1:0] d_q [DEPTH];
      for (genvar k = 0; k < DEPTH; k++) begin : g_stg
        logic          v_src;
        logic [DW-1:0] d_src;
        if (k == 0) begin : g_first
          assign v_src = i_vld;
          assign d_src = i_dat;
        end else begin : g_next
          assign v_src = v_q[k-1];
          assign d_src = d_q[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) v_q[k] <= 1'b0;
          else        v_q[k] <= v_src;
        end
        always_ff @(posedge clk) begin
          if (v_src) d_q[k] <= d_src;
        end
      end
      assign o_vld = v_q[DEPTH-1];
      assign o_dat = d_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/hilbert_bfly.sv
module hilbert_bfly
  import hbf_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_ar,
  input  logic signed [W-1:0] in_ai,
  input  logic signed [W-1:0] in_br,
  input  logic signed [W-1:0] in_bi,
  input  logic signed [W-1:0] tw_cos,
  input  logic signed [W-1:0] tw_sin,
  input  logic                par,
  input  logic                swp_en,
  input  logic                clr_en,
  input  logic                rot_en,
  input  logic                cnj_en,
  output logic                out_vld,
  output logic signed [W-1:0] out_ar,
  output logic signed [W-1:0] out_ai,
  output logic signed [W-1:0] out_br,
  output logic signed [W-1:0] out_bi
);
  localparam int TAIL = LAT - 2;
  localparam int PW   = 4 * W;

  // stage 1: operand exchange, sum, difference, rotation
  logic signed [W-1:0] p_xr, p_xi, p_yr, p_yi, p_sr, p_si, p_dr, p_di;
  logic signed [W-1:0] s1_xr, s1_xi, s1_yr, s1_yi, s1_sr, s1_si, s1_dr, s1_di;
  logic signed [W-1:0] s1_c, s1_s;
  hbf_mode_t           m_d, s1_m;
  logic                s1_vld;

  hbf_prep #(.W(W)) u_prep (
    .par(par), .rot(rot_en & ~swp_en),
    .ar(in_ar), .ai(in_ai), .br(in_br), .bi(in_bi),
    .xr(p_xr), .xi(p_xi), .yr(p_yr), .yi(p_yi),
    .sr(p_sr), .si(p_si), .dr(p_dr), .di(p_di)
  );

  always_comb begin
    m_d.clr = clr_en;
    m_d.swp = swp_en;
    m_d.cnj = cnj_en;
    m_d.par = par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else        s1_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      s1_xr <= p_xr;  s1_xi <= p_xi;  s1_yr <= p_yr;  s1_yi <= p_yi;
      s1_sr <= p_sr;  s1_si <= p_si;  s1_dr <= p_dr;  s1_di <= p_di;
      s1_c  <= tw_cos; s1_s <= tw_sin;
      s1_m  <= m_d;
    end
  end

  // stage 2: twiddle product, mode select, conjugate, result exchange
  logic signed [W-1:0] m_pr, m_pi;
  logic signed [W-1:0] u_ar, u_ai, u_br, u_bi;
  logic signed [W-1:0] v_ai, v_bi;
  logic signed [W-1:0] n_ar, n_ai, n_br, n_bi;
  logic signed [W-1:0] s2_ar, s2_ai, s2_br, s2_bi;
  logic                s2_vld;

  hbf_cmul #(.W(W)) u_cmul (
    .dr(s1_dr), .di(s1_di), .c(s1_c), .s(s1_s), .pr(m_pr), .pi(m_pi)
  );

  always_comb begin
    if (s1_m.clr) begin
      u_ar = '0; u_ai = '0; u_br = '0; u_bi = '0;
    end else if (s1_m.swp) begin
      u_ar = s1_yi; u_ai = s1_yr; u_br = s1_xi; u_bi = s1_xr;
    end else begin
      u_ar = s1_sr; u_ai = s1_si; u_br = m_pr; u_bi = m_pi;
    end
    v_ai = s1_m.cnj ? -u_ai : u_ai;
    v_bi = s1_m.cnj ? -u_bi : u_bi;
    n_ar = s1_m.par ? u_br : u_ar;
    n_ai = s1_m.par ? v_bi : v_ai;
    n_br = s1_m.par ? u_ar : u_br;
    n_bi = s1_m.par ? v_ai : v_bi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_vld <= 1'b0;
    else        s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_ar <= n_ar; s2_ai <= n_ai; s2_br <= n_br; s2_bi <= n_bi;
    end
  end

  // remaining latency
  logic [PW-1:0] t_dat;

  hbf_dly #(.DW(PW), .DEPTH(TAIL)) u_tail (
    .clk(clk), .rst_n(rst_n),
    .i_vld(s2_vld), .i_dat({s2_ar, s2_ai, s2_br, s2_bi}),
    .o_vld(out_vld), .o_dat(t_dat)
  );

  assign out_ar = t_dat[4*W-1:3*W];
  assign out_ai = t_dat[3*W-1:2*W];
  assign out_br = t_dat[2*W-1:W];
  assign out_bi = t_dat[W-1:0];
endmodule

// File: rtl/hbf_chk.sv
module hbf_chk #(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_vld,
  input logic signed [W-1:0] in_ar,
  input logic signed [W-1:0] in_ai,
  input logic signed [W-1:0] in_br,
  input logic signed [W-1:0] in_bi,
  input logic                swp_en,
  input logic                clr_en,
  input logic                cnj_en,
  input logic                out_vld,
  input logic signed [W-1:0] out_ar,
  input logic signed [W-1:0] out_ai,
  input logic signed [W-1:0] out_br,
  input logic signed [W-1:0] out_bi
);
  logic [LAT-1:0]      h_vld, h_clr, h_swp, h_cnj;
  logic signed [W-1:0] h_ar [LAT];
  logic signed [W-1:0] h_ai [LAT];
  logic signed [W-1:0] h_br [LAT];
  logic signed [W-1:0] h_bi [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld <= '0; h_clr <= '0; h_swp <= '0; h_cnj <= '0;
      for (int k = 0; k < LAT; k++) begin
        h_ar[k] <= '0; h_ai[k] <= '0; h_br[k] <= '0; h_bi[k] <= '0;
      end
    end else begin
      h_vld <= {h_vld[LAT-2:0], in_vld};
      h_clr <= {h_clr[LAT-2:0], clr_en};
      h_swp <= {h_swp[LAT-2:0], swp_en};
      h_cnj <= {h_cnj[LAT-2:0], cnj_en};
      h_ar[0] <= in_ar; h_ai[0] <= in_ai; h_br[0] <= in_br; h_bi[0] <= in_bi;
      for (int k = 1; k < LAT; k++) begin
        h_ar[k] <= h_ar[k-1]; h_ai[k] <= h_ai[k-1];
        h_br[k] <= h_br[k-1]; h_bi[k] <= h_bi[k-1];
      end
    end
  end

  logic signed [W-1:0] e_ai, e_bi;
  always_comb begin
    e_ai = h_cnj[LAT-1] ? -h_br[LAT-1] : h_br[LAT-1];
    e_bi = h_cnj[LAT-1] ? -h_ar[LAT-1] : h_ar[LAT-1];
  end

  // R8
  r8_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == h_vld[LAT-1]);

  // R5
  r5_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && h_clr[LAT-1]) |->
      (out_ar == '0 && out_ai == '0 && out_br == '0 && out_bi == '0));

  // R4
  r4_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && h_swp[LAT-1] && !h_clr[LAT-1]) |->
      (out_ar == h_bi[LAT-1] && out_br == h_ai[LAT-1]));

  // R6
  r6_conj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && h_swp[LAT-1] && !h_clr[LAT-1]) |->
      (out_ai == e_ai && out_bi == e_bi));

  // R9
  always @(posedge clk) begin
    if (!rst_n) r9_reset_chk: assert (!out_vld);
  end
endmodule

bind hilbert_bfly hbf_chk #(.W(W), .LAT(LAT)) u_chk (.*);

// File: tb/sim_hilbert_bfly.sv
module sim_hilbert_bfly;
  localparam int W   = 16;
  localparam int LAT = 3;

  typedef struct {
    bit     vld;
    longint ar, ai, br, bi;
    string  ta, tb;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic signed [W-1:0] in_ar = '0, in_ai = '0, in_br = '0, in_bi = '0;
  logic signed [W-1:0] tw_cos = '0, tw_sin = '0;
  logic par = 1'b0, swp_en = 1'b0, clr_en = 1'b0, rot_en = 1'b0, cnj_en = 1'b0;
  logic out_vld;
  logic signed [W-1:0] out_ar, out_ai, out_br, out_bi;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  hilbert_bfly #(.W(W), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_ar(in_ar), .in_ai(in_ai), .in_br(in_br), .in_bi(in_bi),
    .tw_cos(tw_cos), .tw_sin(tw_sin), .par(par), .swp_en(swp_en),
    .clr_en(clr_en), .rot_en(rot_en), .cnj_en(cnj_en),
    .out_vld(out_vld), .out_ar(out_ar), .out_ai(out_ai),
    .out_br(out_br), .out_bi(out_bi)
  );

  function automatic longint wr(longint x);
    logic [W-1:0] t;
    t = x[W-1:0];
    return longint'($signed(t));
  endfunction

  function automatic exp_t model(bit v, longint ar, longint ai, longint br, longint bi,
                                 longint c, longint s, bit p, bit z, bit e, bit y, bit j);
    exp_t   r;
    longint xr, xi, yr, yi, dr, di, t, a_r, a_i, b_r, b_i;
    r.vld = v;
    xr = p ? br : ar;  xi = p ? bi : ai;
    yr = p ? ar : br;  yi = p ? ai : bi;
    dr = wr(xr - yr);  di = wr(xi - yi);
    if (y && !e) begin t = dr; dr = di; di = wr(-t); end
    if (z) begin
      a_r = 0; a_i = 0; b_r = 0; b_i = 0;
    end else if (e) begin
      a_r = yi; a_i = yr; b_r = xi; b_i = xr;
    end else begin
      a_r = wr(xr + yr); a_i = wr(xi + yi);
      b_r = wr((dr * c - di * s) >>> (W - 1));
      b_i = wr((dr * s + di * c) >>> (W - 1));
    end
    if (j) begin a_i = wr(-a_i); b_i = wr(-b_i); end
    if (p) begin
      r.ar = b_r; r.ai = b_i; r.br = a_r; r.bi = a_i;
    end else begin
      r.ar = a_r; r.ai = a_i; r.br = b_r; r.bi = b_i;
    end
    if (z)           begin r.ta = "R5";  r.tb = "R5";  end
    else if (e && y) begin r.ta = "R10"; r.tb = "R10"; end
    else if (e)      begin r.ta = "R4";  r.tb = "R4";  end
    else if (p)      begin r.ta = "R7";  r.tb = "R7";  end
    else if (j)      begin r.ta = "R6";  r.tb = "R6";  end
    else if (y)      begin r.ta = "R3";  r.tb = "R3";  end
    else             begin r.ta = "R1";  r.tb = "R2";  end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_out();
    exp_t e;
    if (q.size() == LAT) begin
      e = q.pop_front();
      chk(out_vld == e.vld, "R8", longint'(out_vld), longint'(e.vld));
      if (e.vld && out_vld) begin
        chk(out_ar == e.ar, e.ta, out_ar, e.ar);
        chk(out_ai == e.ai, e.ta, out_ai, e.ai);
        chk(out_br == e.br, e.tb, out_br, e.br);
        chk(out_bi == e.bi, e.tb, out_bi, e.bi);
      end
    end
  endtask

  task automatic drive(bit v, bit p, bit z, bit e, bit y, bit j);
    in_vld = v;
    in_ar  = W'($urandom); in_ai = W'($urandom);
    in_br  = W'($urandom); in_bi = W'($urandom);
    tw_cos = W'($urandom); tw_sin = W'($urandom);
    par = p; clr_en = z; swp_en = e; rot_en = y; cnj_en = j;
    q.push_back(model(v, in_ar, in_ai, in_br, in_bi, tw_cos, tw_sin, p, z, e, y, j));
  endtask

  task automatic cycle(bit v, bit p, bit z, bit e, bit y, bit j);
    @(negedge clk);
    check_out();
    drive(v, p, z, e, y, j);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_vld == 1'b0, "R9", longint'(out_vld), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 60; i++) cycle(1'b1, 0, 0, 0, 0, 0);           // R1 R2
    for (int i = 0; i < 60; i++) cycle(($urandom % 4) != 0, 0, 0, 0, 0, 0); // R8 gaps
    for (int i = 0; i < 40; i++) cycle(1'b1, 0, 0, 0, 1, 0);           // R3
    for (int i = 0; i < 40; i++) cycle(1'b1, $urandom % 2, 0, 1, 0, 0); // R4
    for (int i = 0; i < 40; i++) cycle(1'b1, $urandom % 2, 0, 1, 1, $urandom % 2); // R10
    for (int i = 0; i < 40; i++) cycle(1'b1, $urandom % 2, 1, $urandom % 2, $urandom % 2, $urandom % 2); // R5
    for (int i = 0; i < 40; i++) cycle(1'b1, 0, 0, $urandom % 2, $urandom % 2, 1); // R6
    for (int i = 0; i < 40; i++) cycle(1'b1, 1, 0, 0, $urandom % 2, $urandom % 2); // R7
    for (int i = 0; i < 200; i++)
      cycle(($urandom % 3) != 0, $urandom % 2, ($urandom % 8) == 0, $urandom % 2,
            $urandom % 2, $urandom % 2);
    for (int i = 0; i < LAT + 2; i++) cycle(1'b0, 0, 0, 0, 0, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule